// File: doc/BRIEF.md
# Upstream Request Tagger and Translator

This block sits between the graphics-port request arbiter and the link packet builder. Each accepted request names its kind (read, write, flush or fence), its priority (high or low) and whether it belongs to the PCI-compatible path. The block answers in the same cycle with a link request descriptor. The descriptor holds the link command, whether the request travels in the posted channel, the ordering bit for the request and for its response, a source tag, and which of the block's unit identifiers to use.

Graphics requests that expect a response draw tags from a wrapping counter. A second counter tracks how many of them are still waiting for a response, and each response pulse frees one. A request stalls when every graphics tag is in use. A fence produces no link command: it is held back until every outstanding graphics response has come home, and it then completes silently. PCI-path requests that expect a response share one fixed tag and are neither counted nor stalled.

Top module: `urt_top`

## Requirements
- R1: After reset the outstanding count is zero, so `req_ready` is 1 for every request kind, and the first graphics tag handed out is 0.
- R2: Graphics reads and flushes (`req_pci`=0) receive tags 0, 1, 2, … up to NUM_GFX_TAGS-1 (27 by default), and the tag after that is 0 again.
- R3: No more than NUM_GFX_TAGS graphics reads and flushes are outstanding at once. While that many are outstanding, `req_ready` is 0 for a graphics read or flush. Each `rsp_valid` pulse frees one tag.
- R4: A PCI-path read or flush (`req_pci`=1) always carries tag NUM_GFX_TAGS (28). It is never stalled and does not change the outstanding count or the graphics tag sequence.
- R5: A write (`req_kind`=1) gives `out_cmd`=0 (sized write), `out_posted`=1, `out_pass_pw` equal to `req_hipri`, `out_rsp_pass_pw`=0 and `out_tag`=0. It consumes no tag, is never stalled, and is not counted as outstanding.
- R6: A read (`req_kind`=0) gives `out_cmd`=1 (sized read), `out_posted`=0, `out_pass_pw` equal to `req_hipri`, and `out_rsp_pass_pw`=1.
- R7: A flush (`req_kind`=2) gives `out_cmd`=2, `out_posted`=0, `out_pass_pw`=0 and `out_rsp_pass_pw`=0 whatever the priority, and it consumes a tag like a read.
- R8: A fence (`req_kind`=3) never raises `out_valid`. It is accepted (`req_ready`=1) only while no graphics response is outstanding.
- R9: `out_unit_sel` is 1 for PCI-path requests and 2 for graphics requests, and it is never 0.
- R10: `out_valid` is 1 exactly in a cycle where `req_valid` and `req_ready` are both 1 and the request is not a fence. The descriptor on the outputs is valid in that same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted at this clock edge when valid |
| req_kind | input | 2 | 0 read, 1 write, 2 flush, 3 fence |
| req_hipri | input | 1 | 1 = high priority |
| req_pci | input | 1 | 1 = PCI-path request |
| rsp_valid | input | 1 | One graphics response has returned |
| out_valid | output | 1 | Descriptor valid this cycle |
| out_cmd | output | 2 | 0 sized write, 1 sized read, 2 flush |
| out_posted | output | 1 | Travels in the posted channel |
| out_pass_pw | output | 1 | Request may pass posted writes |
| out_rsp_pass_pw | output | 1 | Response may pass posted writes |
| out_tag | output | TAG_W | Source tag |
| out_unit_sel | output | 2 | Index of unit identifier (1 PCI, 2 graphics) |

## Verification
The bench builds the block with the default NUM_GFX_TAGS of 28. With that value the whole tag ring and the full-stall condition fit into a few dozen cycles. A single run can therefore fill every tag, watch the wrap from 27 to 0, probe the stall with reads, flushes and fences while full, and slip PCI-path requests and writes past the stall. Responses are then returned one by one, which shows a single freed tag reopening the path and fences waiting until the count drains to zero.

// File: rtl/urt_pkg.sv
package urt_pkg;

    typedef enum logic [1:0] {
        RK_READ  = 2'd0,
        RK_WRITE = 2'd1,
        RK_FLUSH = 2'd2,
        RK_FENCE = 2'd3
    } req_kind_e;

    typedef enum logic [1:0] {
        LC_WRSIZED = 2'd0,
        LC_RDSIZED = 2'd1,
        LC_FLUSH   = 2'd2
    } link_cmd_e;

    localparam logic [1:0] UNIT_PCI = 2'd1;
    localparam logic [1:0] UNIT_GFX = 2'd2;

    typedef struct packed {
        link_cmd_e  cmd;
        logic       posted;
        logic       pass_pw;
        logic       rsp_pass_pw;
        logic [1:0] unit_sel;
    } link_desc_t;

    function automatic logic needs_rsp(input req_kind_e k);
        return (k == RK_READ) || (k == RK_FLUSH);
    endfunction

endpackage

// File: rtl/urt_tag_alloc.sv
module urt_tag_alloc #(
    parameter int NUM_TAGS = 28,
    parameter int TAG_W    = 5,
    parameter int CNT_W    = 5
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             issue,
    input  logic             retire,
    output logic             full,
    output logic             empty,
    output logic [TAG_W-1:0] tag
);
    localparam logic [TAG_W-1:0] TAG_LAST = TAG_W'(NUM_TAGS - 1);
    localparam logic [CNT_W-1:0] CNT_MAX  = CNT_W'(NUM_TAGS);

    logic [CNT_W-1:0] cnt;
    logic             dec;

    assign dec   = retire && (cnt != '0);
    assign full  = (cnt == CNT_MAX);
    assign empty = (cnt == '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            tag <= '0;
            cnt <= '0;
        end else begin
            if (issue) begin
                tag <= (tag == TAG_LAST) ? '0 : tag + 1'b1;
            end
            case ({issue, dec})
                2'b10:   cnt <= cnt + 1'b1;
                2'b01:   cnt <= cnt - 1'b1;
                default: cnt <= cnt;
            endcase
        end
    end

    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst) retire |-> !empty); // R3
    AST_NO_OVERFLOW:  assert property (@(posedge clk) disable iff (rst) issue |-> !full);   // R3
    AST_TAG_WRAP:     assert property (@(posedge clk) disable iff (rst)
                          (issue && tag == TAG_LAST) |=> (tag == '0));                    // R2
    AST_TAG_RANGE:    assert property (@(posedge clk) disable iff (rst) tag <= TAG_LAST); // R2

endmodule

// File: rtl/urt_xlate.sv
module urt_xlate
    import urt_pkg::*;
#(
    parameter int TAG_W   = 5,
    parameter int PCI_TAG = 28
) (
    input  req_kind_e        kind,
    input  logic             hipri,
    input  logic             pci,
    input  logic [TAG_W-1:0] gfx_tag,
    output link_desc_t       desc,
    output logic [TAG_W-1:0] tag
);
    always_comb begin
        desc.unit_sel    = pci ? UNIT_PCI : UNIT_GFX;
        desc.posted      = 1'b0;
        desc.pass_pw     = 1'b0;
        desc.rsp_pass_pw = 1'b0;
        desc.cmd         = LC_FLUSH;
        case (kind)
            RK_WRITE: begin
                desc.cmd     = LC_WRSIZED;
                desc.posted  = 1'b1;
                desc.pass_pw = hipri;
            end
            RK_READ: begin
                desc.cmd         = LC_RDSIZED;
                desc.pass_pw     = hipri;
                desc.rsp_pass_pw = 1'b1;
            end
            default: desc.cmd = LC_FLUSH;
        endcase

        if (kind == RK_WRITE) begin
            tag = '0;
        end else if (pci) begin
            tag = TAG_W'(PCI_TAG);
        end else begin
            tag = gfx_tag;
        end
    end
endmodule

// File: rtl/urt_top.sv
module urt_top
    import urt_pkg::*;
#(
    parameter  int NUM_GFX_TAGS = 28,
    localparam int TAG_W        = $clog2(NUM_GFX_TAGS + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             req_valid,
    output logic             req_ready,
    input  logic [1:0]       req_kind,
    input  logic             req_hipri,
    input  logic             req_pci,
    input  logic             rsp_valid,
    output logic             out_valid,
    output logic [1:0]       out_cmd,
    output logic             out_posted,
    output logic             out_pass_pw,
    output logic             out_rsp_pass_pw,
    output logic [TAG_W-1:0] out_tag,
    output logic [1:0]       out_unit_sel
);
    localparam int CNT_W = $clog2(NUM_GFX_TAGS + 1);

    req_kind_e        kind;
    logic             gfx_np;
    logic             is_fence;
    logic             tags_full;
    logic             none_out;
    logic             issue;
    logic [TAG_W-1:0] gfx_tag;
    link_desc_t       desc;

    assign kind     = req_kind_e'(req_kind);
    assign is_fence = (kind == RK_FENCE);
    assign gfx_np   = !req_pci && needs_rsp(kind);

    always_comb begin
        if (is_fence)    req_ready = none_out;
        else if (gfx_np) req_ready = !tags_full;
        else             req_ready = 1'b1;
    end

    assign out_valid = req_valid && req_ready && !is_fence;
    assign issue     = out_valid && gfx_np;

    urt_tag_alloc #(
        .NUM_TAGS (NUM_GFX_TAGS),
        .TAG_W    (TAG_W),
        .CNT_W    (CNT_W)
    ) tag_i (
        .clk    (clk),
        .rst    (rst),
        .issue  (issue),
        .retire (rsp_valid),
        .full   (tags_full),
        .empty  (none_out),
        .tag    (gfx_tag)
    );

    urt_xlate #(
        .TAG_W   (TAG_W),
        .PCI_TAG (NUM_GFX_TAGS)
    ) xl_i (
        .kind    (kind),
        .hipri   (req_hipri),
        .pci     (req_pci),
        .gfx_tag (gfx_tag),
        .desc    (desc),
        .tag     (out_tag)
    );

    assign out_cmd         = desc.cmd;
    assign out_posted      = desc.posted;
    assign out_pass_pw     = desc.pass_pw;
    assign out_rsp_pass_pw = desc.rsp_pass_pw;
    assign out_unit_sel    = desc.unit_sel;

    AST_FENCE_SILENT: assert property (@(posedge clk) disable iff (rst)
                          (req_valid && is_fence) |-> !out_valid);                       // R8
    AST_FENCE_DRAINED: assert property (@(posedge clk) disable iff (rst)
                          (req_valid && is_fence && req_ready) |-> none_out);            // R8
    AST_UNIT_NONZERO: assert property (@(posedge clk) disable iff (rst)
                          out_valid |-> (out_unit_sel != 2'd0));                         // R9
    AST_PCI_FIXED_TAG: assert property (@(posedge clk) disable iff (rst)
                          (out_valid && req_pci && !out_posted) |-> (out_tag == TAG_W'(NUM_GFX_TAGS))); // R4
    AST_PCI_NO_STALL: assert property (@(posedge clk) disable iff (rst)
                          (req_valid && req_pci && !is_fence) |-> req_ready);            // R4
    AST_POSTED_TAG_FREE: assert property (@(posedge clk) disable iff (rst)
                          (out_valid && out_posted) |=> $stable(gfx_tag));               // R5

endmodule

// File: tb/urt_top_tb_top.sv
module urt_top_tb_top;
    localparam int NT    = 28;
    localparam int TAG_W = $clog2(NT + 1);

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic [1:0]       req_kind = 2'd0;
    logic             req_hipri = 1'b0;
    logic             req_pci = 1'b0;
    logic             rsp_valid = 1'b0;
    logic             out_valid;
    logic [1:0]       out_cmd;
    logic             out_posted;
    logic             out_pass_pw;
    logic             out_rsp_pass_pw;
    logic [TAG_W-1:0] out_tag;
    logic [1:0]       out_unit_sel;

    int tests = 0;
    int fails = 0;
    int m_tag = 0;
    int m_cnt = 0;
    bit done  = 1'b0;

    typedef logic [TAG_W+6:0] item_t; // {cmd, posted, pass, rsp_pass, tag, unit}
    item_t exp_q[$];
    string why_q[$];

    always #5 clk = ~clk;

    urt_top #(.NUM_GFX_TAGS(NT)) dut_i (
        .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
        .req_kind(req_kind), .req_hipri(req_hipri), .req_pci(req_pci),
        .rsp_valid(rsp_valid), .out_valid(out_valid), .out_cmd(out_cmd),
        .out_posted(out_posted), .out_pass_pw(out_pass_pw),
        .out_rsp_pass_pw(out_rsp_pass_pw), .out_tag(out_tag),
        .out_unit_sel(out_unit_sel)
    );

    task automatic check(input bit ok, input string msg, input int act, input int exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
        end
    endtask

    // monitor: compare every descriptor against the scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (out_valid) begin
                item_t got;
                got = {out_cmd, out_posted, out_pass_pw, out_rsp_pass_pw, out_tag, out_unit_sel};
                if (exp_q.size() == 0) begin
                    check(1'b0, "R10/R8 unexpected descriptor", int'(got), -1);
                end else begin
                    item_t e;
                    string w;
                    e = exp_q.pop_front();
                    w = why_q.pop_front();
                    check(got == e, w, int'(got), int'(e));
                end
            end else if (exp_q.size() != 0) begin
                string w;
                w = why_q.pop_front();
                check(1'b0, {w, " missing descriptor (R10)"}, 0, int'(exp_q.pop_front()));
            end
        end
    end

    function automatic item_t model(input int k, input bit hi, input bit pci);
        logic [1:0] cmd, unit;
        bit p, pw, rpw;
        int tg;
        unit = pci ? 2'd1 : 2'd2;
        case (k)
            1: begin cmd = 2'd0; p = 1; pw = hi; rpw = 0; tg = 0; end
            0: begin cmd = 2'd1; p = 0; pw = hi; rpw = 1; tg = pci ? NT : m_tag; end
            default: begin cmd = 2'd2; p = 0; pw = 0; rpw = 0; tg = pci ? NT : m_tag; end
        endcase
        return {cmd, p, pw, rpw, TAG_W'(tg), unit};
    endfunction

    // driver: present one request, wait for ready, push expectation
    task automatic send(input int k, input bit hi, input bit pci, input string why);
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = 2'(k); req_hipri = hi; req_pci = pci;
        #2;
        while (!req_ready) begin
            @(posedge clk); #3;
        end
        if (k != 3) begin
            exp_q.push_back(model(k, hi, pci));
            why_q.push_back(why);
            if (!pci && (k == 0 || k == 2)) begin
                m_tag = (m_tag == NT - 1) ? 0 : m_tag + 1;
                m_cnt++;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    // probe: present one request for a cycle and check ready
    task automatic probe(input int k, input bit pci, input bit exp_rdy, input string why);
        @(posedge clk); #1;
        req_valid = 1'b1; req_kind = 2'(k); req_hipri = 1'b1; req_pci = pci;
        #2;
        check(req_ready == exp_rdy, why, int'(req_ready), int'(exp_rdy));
        if (req_ready && k != 3) begin
            exp_q.push_back(model(k, 1'b1, pci));
            why_q.push_back(why);
            if (!pci && (k == 0 || k == 2)) begin
                m_tag = (m_tag == NT - 1) ? 0 : m_tag + 1;
                m_cnt++;
            end
        end
        @(posedge clk); #1;
        req_valid = 1'b0;
    endtask

    task automatic ret(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            rsp_valid = 1'b1;
            m_cnt--;
        end
        @(posedge clk); #1;
        rsp_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        // R1: reset state
        req_kind = 2'd3;
        #2;
        check(req_ready == 1'b1, "R1 fence ready after reset", int'(req_ready), 1);
        check(out_valid == 1'b0, "R1 no descriptor after reset", int'(out_valid), 0);
        req_kind = 2'd0;
        #1;
        check(req_ready == 1'b1, "R1 read ready after reset", int'(req_ready), 1);

        send(1, 1, 0, "R5 high write");
        send(1, 0, 0, "R5 low write");
        send(0, 1, 0, "R6/R1 high read first tag 0");
        send(0, 0, 0, "R6 low read");
        send(2, 1, 0, "R7 flush high prio");
        send(0, 0, 1, "R4/R9 PCI read");
        send(2, 0, 1, "R4 PCI flush");
        send(1, 1, 1, "R9 PCI write");
        probe(3, 0, 1'b0, "R8 fence stalls with outstanding");
        ret(3);
        send(3, 0, 0, "R8 fence after drain");

        for (int i = 0; i < NT; i++) send(0, i[0], 0, "R2 read tag ring");
        probe(0, 0, 1'b0, "R3 read stalls when full");
        probe(2, 0, 1'b0, "R3 flush stalls when full");
        probe(3, 0, 1'b0, "R8 fence stalls when full");
        probe(0, 1, 1'b1, "R4 PCI read passes when full");
        probe(1, 0, 1'b1, "R5 write passes when full");
        ret(1);
        send(0, 1, 0, "R3 freed tag reused");
        ret(m_cnt);
        send(3, 1, 0, "R8 fence after full drain");
        send(2, 0, 0, "R7 flush after fence");
        ret(1);
        repeat (3) @(posedge clk);
        #3;
        check(exp_q.size() == 0, "R10 scoreboard drained", exp_q.size(), 0);
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

    initial begin
        #200000;
        if (!done) begin
            tests++;
            fails++;
            $display("FAIL watchdog R10 actual=%0d expected=%0d", 0, 1);
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end
endmodule